// File: doc/BRIEF.md
# Transmit Squelch and Blanking Controller

This block stands between the attachment-side transmit input and the coax line driver. Each clock it takes one sample of the transmit data polarity and one bit from an external amplitude comparator. That bit says whether the input swing is above the squelch threshold. A pulse is a run of above-threshold samples that all have the same polarity. Only runs long enough to rule out noise count as qualified pulses, and only a qualified pulse can switch the transmitter on.

While qualified pulses keep arriving, the block holds the transmitter enabled. It passes the sampled data through without inversion, and forces the data low on any sample that falls below the threshold. When no qualified pulse has been seen for a full timeout window, the block turns the transmitter off cleanly. It then emits a one-cycle end-of-transmit strobe for downstream timers, such as a heartbeat or jabber reset timer. Next comes a blanking interval, during which trailing dribble bits cannot restart transmission. A separate disable input, driven by a jabber guard, blocks the enable and the data path. It leaves the data-valid indication untouched so that the guard can keep timing the activity.

Top module: `txsq_ctrl`

## Requirements
- R1: On a cycle whose sample has `thr_ok_i` low, that sample never counts toward a pulse, and `tx_data_o` is 0 after that clock edge.
- R2: A run of fewer than MIN_PULSE (default 3) consecutive above-threshold samples of the same polarity never starts transmission. Runs that alternate polarity every MIN_PULSE-1 samples never start it either.
- R3: From idle, a run of MIN_PULSE same-polarity samples raises `tx_valid_o` and `tx_en_o` after the clock edge that follows the run's MIN_PULSE-th sample, and not before.
- R4: `tx_valid_o` falls exactly IDLE_TO (default 20) cycles after the cycle in which the last qualified pulse was taken. An isolated qualified pulse therefore gives a valid window of exactly IDLE_TO cycles.
- R5: `eot_o` is high for exactly one cycle, in the same cycle in which `tx_valid_o` falls because of the timeout, and at no other time.
- R6: For BLANK_LEN (default 20) cycles after `tx_valid_o` falls, qualified pulses are ignored and `tx_valid_o` stays low. A pulse qualified after the interval starts a new transmission.
- R7: While `tx_en_o` is high, `tx_data_o` equals the `tx_data_i` sample taken at the previous clock edge whenever that sample was above threshold, with no inversion.
- R8: `tx_data_o` is 0 in every cycle in which `tx_en_o` is 0, so the output goes straight to idle when the transmitter is turned off.
- R9: When `jab_dis_i` is high at a clock edge, `tx_en_o` and `tx_data_o` are 0 after that edge, while `tx_valid_o` still follows input activity.
- R10: While `rst` is high, all four outputs are 0 after each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock (one sample per cycle) |
| rst | input | 1 | Synchronous active-high reset |
| tx_data_i | input | 1 | Sampled transmit data polarity |
| thr_ok_i | input | 1 | Amplitude comparator: 1 when the input swing exceeds the squelch threshold |
| jab_dis_i | input | 1 | Forced disable from the jabber guard |
| tx_en_o | output | 1 | Transmit driver enable |
| tx_data_o | output | 1 | Gated, non-inverted transmit data |
| tx_valid_o | output | 1 | Qualified transmit activity in progress |
| eot_o | output | 1 | One-cycle end-of-transmit strobe |

## Verification
The checker runs on every cycle and covers the port relations that are local in time. These are: data held low whenever the enable is low; below-threshold samples producing no output data; non-inverted data pass-through; the jabber block on the next cycle; and the end-of-transmit strobe coinciding with, and confined to, the drop of data-valid. A counter in the checker also enforces the blanking hold after every drop. The bench scenarios show the parts that depend on exact stimulus shapes. These are: rejection of short and alternating runs, the exact start latency, the exact timeout window after an isolated pulse and after a Manchester-coded frame, and a pulse qualified just inside versus just after the blanking window.

// File: rtl/txsq_pkg.sv
`timescale 1ns/1ps
package txsq_pkg;

  // Transmit path state
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_BLANK  = 2'd2
  } txsq_state_e;

endpackage

// File: rtl/txsq_pulse_qual.sv
`timescale 1ns/1ps
// Pulse width qualifier: measures runs of above-threshold samples of one
// polarity and emits a single-cycle strobe when a run reaches MIN_PULSE.
module txsq_pulse_qual #(
  parameter int MIN_PULSE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_d,
  input  logic smp_thr,
  output logic qual_o
);

  localparam int RW = $clog2(MIN_PULSE + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(MIN_PULSE);

  logic [RW-1:0] run_q;
  logic [RW-1:0] run_n;
  logic          pol_q;
  logic          cont;

  always_comb begin
    cont = smp_thr && (run_q != '0) && (pol_q == smp_d);
    if (!smp_thr) begin
      run_n = '0;
    end else if (cont) begin
      run_n = (run_q == RUN_MAX) ? RUN_MAX : run_q + 1'b1;
    end else begin
      run_n = RW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      pol_q  <= 1'b0;
      qual_o <= 1'b0;
    end else begin
      run_q  <= run_n;
      pol_q  <= smp_d;
      qual_o <= (run_n == RUN_MAX) && !(cont && (run_q == RUN_MAX));
    end
  end

endmodule

// File: rtl/txsq_span_cnt.sv
`timescale 1ns/1ps
// Interval counter: counts cycles while run is high, flags the last one.
module txsq_span_cnt #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic last_o
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = run && (cnt_q == CNT_END);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/txsq_ctrl.sv
`timescale 1ns/1ps
// Transmit squelch and blanking controller (top).
module txsq_ctrl #(
  parameter int MIN_PULSE = 3,
  parameter int IDLE_TO   = 20,
  parameter int BLANK_LEN = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_data_i,
  input  logic thr_ok_i,
  input  logic jab_dis_i,
  output logic tx_en_o,
  output logic tx_data_o,
  output logic tx_valid_o,
  output logic eot_o
);

  import txsq_pkg::*;

  txsq_state_e st_q;
  txsq_state_e st_n;
  logic        qual;
  logic        gap_last;
  logic        blank_last;
  logic        pass;

  txsq_pulse_qual #(.MIN_PULSE(MIN_PULSE)) qual_i (
    .clk     (clk),
    .rst     (rst),
    .smp_d   (tx_data_i),
    .smp_thr (thr_ok_i),
    .qual_o  (qual)
  );

  // Gap timer: restarts on every qualified pulse while active
  txsq_span_cnt #(.LIMIT(IDLE_TO)) gap_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (qual || (st_q != ST_ACTIVE)),
    .run    (st_q == ST_ACTIVE),
    .last_o (gap_last)
  );

  // Blanking timer: runs only in the post-frame state
  txsq_span_cnt #(.LIMIT(BLANK_LEN)) blank_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (st_q != ST_BLANK),
    .run    (st_q == ST_BLANK),
    .last_o (blank_last)
  );

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE:   if (qual) st_n = ST_ACTIVE;
      ST_ACTIVE: if (!qual && gap_last) st_n = ST_BLANK;
      ST_BLANK:  if (blank_last) st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  assign pass = (st_n == ST_ACTIVE) && !jab_dis_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      tx_valid_o <= 1'b0;
      tx_en_o    <= 1'b0;
      tx_data_o  <= 1'b0;
      eot_o      <= 1'b0;
    end else begin
      st_q       <= st_n;
      tx_valid_o <= (st_n == ST_ACTIVE);
      tx_en_o    <= pass;
      tx_data_o  <= pass && thr_ok_i && tx_data_i;
      eot_o      <= (st_q == ST_ACTIVE) && (st_n == ST_BLANK);
    end
  end

endmodule

// File: rtl/txsq_ctrl_chk.sv
`timescale 1ns/1ps
module txsq_ctrl_chk #(
  parameter int BLANK_LEN = 20
) (
  input logic clk,
  input logic rst,
  input logic tx_data_i,
  input logic thr_ok_i,
  input logic jab_dis_i,
  input logic tx_en_o,
  input logic tx_data_o,
  input logic tx_valid_o,
  input logic eot_o
);

  localparam int BW = $clog2(BLANK_LEN + 1);

  logic [BW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (!tx_valid_o && eot_o) begin
      hold_q <= BW'(BLANK_LEN - 1);
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end
  end

  // R8
  quiet_off_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en_o |-> !tx_data_o);

  // R1
  below_thr_chk: assert property (@(posedge clk) disable iff (rst)
    !thr_ok_i |=> !tx_data_o);

  // R7
  no_invert_chk: assert property (@(posedge clk) disable iff (rst)
    thr_ok_i ##1 tx_en_o |-> (tx_data_o == $past(tx_data_i)));

  // R9
  jab_block_chk: assert property (@(posedge clk) disable iff (rst)
    jab_dis_i |=> !tx_en_o);

  // R9
  en_in_valid_chk: assert property (@(posedge clk) disable iff (rst)
    tx_en_o |-> tx_valid_o);

  // R5
  eot_at_drop_chk: assert property (@(posedge clk) disable iff (rst)
    eot_o |-> $fell(tx_valid_o));

  // R5
  drop_has_eot_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_valid_o) |-> eot_o);

  // R5
  eot_single_chk: assert property (@(posedge clk) disable iff (rst)
    eot_o |=> !eot_o);

  // R6
  blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_q != '0) |-> !tx_valid_o);

endmodule

bind txsq_ctrl txsq_ctrl_chk #(.BLANK_LEN(BLANK_LEN)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .tx_data_i  (tx_data_i),
  .thr_ok_i   (thr_ok_i),
  .jab_dis_i  (jab_dis_i),
  .tx_en_o    (tx_en_o),
  .tx_data_o  (tx_data_o),
  .tx_valid_o (tx_valid_o),
  .eot_o      (eot_o)
);

// File: tb/txsq_ctrl_tb_top.sv
`timescale 1ns/1ps
module txsq_ctrl_tb_top;

  localparam int MP = 3;
  localparam int TO = 20;
  localparam int BL = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_data_i = 1'b0;
  logic thr_ok_i = 1'b0;
  logic jab_dis_i = 1'b0;
  logic tx_en_o, tx_data_o, tx_valid_o, eot_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  txsq_ctrl #(.MIN_PULSE(MP), .IDLE_TO(TO), .BLANK_LEN(BL)) dut_i (
    .clk(clk), .rst(rst), .tx_data_i(tx_data_i), .thr_ok_i(thr_ok_i),
    .jab_dis_i(jab_dis_i), .tx_en_o(tx_en_o), .tx_data_o(tx_data_o),
    .tx_valid_o(tx_valid_o), .eot_o(eot_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Apply one sample, let one edge consume it, settle just after the edge
  task automatic tick(input logic d, input logic t);
    tx_data_i = d;
    thr_ok_i  = t;
    @(posedge clk);
    #1;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b1);
    check("R10 reset valid", tx_valid_o, 0);
    check("R10 reset en", tx_en_o, 0);
    check("R10 reset data", tx_data_o, 0);
    check("R10 reset eot", eot_o, 0);
    tick(1'b0, 1'b0);
    rst = 1'b0;
    quiet(3);
  endtask

  task automatic t_below_thr();
    int seen = 0;
    for (int i = 0; i < 30; i++) begin
      tick(1'b1, 1'b0);
      seen += tx_valid_o + tx_data_o;
    end
    check("R1 below threshold ignored", seen, 0);
  endtask

  task automatic t_short();
    int seen = 0;
    for (int i = 0; i < 40; i++) begin
      tick(((i / (MP - 1)) % 2) == 1, 1'b1);
      seen += tx_valid_o;
    end
    for (int i = 0; i < 5; i++) begin
      tick(1'b0, 1'b0);
      seen += tx_valid_o;
    end
    for (int i = 0; i < MP - 1; i++) tick(1'b1, 1'b1);
    for (int i = 0; i < 10; i++) begin
      tick(1'b0, 1'b0);
      seen += tx_valid_o;
    end
    check("R2 short runs rejected", seen, 0);
  endtask

  // Returns after the tick on which valid dropped
  task automatic wait_drop(output int hi, output int eot_at_drop, output int eot_else);
    hi = 0; eot_at_drop = 0; eot_else = 0;
    for (int i = 0; i < 200; i++) begin
      tick(1'b0, 1'b0);
      if (tx_valid_o) begin
        hi++;
        eot_else += eot_o;
      end else begin
        eot_at_drop = eot_o;
        break;
      end
    end
  endtask

  task automatic t_single();
    int hi, ead, eel;
    for (int i = 0; i < MP; i++) begin
      tick(1'b1, 1'b1);
      check("R3 no early start", tx_valid_o, 0);
    end
    tick(1'b0, 1'b0);
    check("R3 valid after qualifying run", tx_valid_o, 1);
    check("R3 enable after qualifying run", tx_en_o, 1);
    wait_drop(hi, ead, eel);
    check("R4 isolated pulse window", hi + 1, TO);
    check("R5 eot at drop", ead, 1);
    check("R5 no eot before drop", eel, 0);
    check("R8 data low when disabled", tx_data_o, 0);
  endtask

  // Called right after the drop tick
  task automatic t_blank();
    int seen = 0;
    for (int j = 1; j <= BL; j++) begin
      tick(1'b1, (j <= MP) || (j >= BL - MP && j <= BL - 1));
      seen += tx_valid_o;
      check("R5 eot single cycle", eot_o, 0);
    end
    tick(1'b0, 1'b0);
    seen += tx_valid_o;
    check("R6 pulses in blanking ignored", seen, 0);
    for (int i = 0; i < MP; i++) tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    check("R6 restart after blanking", tx_valid_o, 1);
    quiet(TO + BL + 5);
  endtask

  task automatic t_frame();
    int bad_en = 0;
    int bad_d = 0;
    int hi, ead, eel;
    for (int i = 0; i < 100; i++) begin
      logic bitv, d;
      bitv = ((i / 10) % 3) == 0;
      d = ((i % 10) < 5) ? ~bitv : bitv;
      tick(d, 1'b1);
      if (i >= MP) begin
        if (tx_en_o !== 1'b1) bad_en++;
        if (tx_data_o !== d) bad_d++;
      end
    end
    check("R4 enable held through frame", bad_en, 0);
    check("R7 data not inverted", bad_d, 0);
    wait_drop(hi, ead, eel);
    check("R4 drop after last pulse", hi, TO - 2);
    check("R5 frame eot", ead, 1);
    quiet(BL + 3);
  endtask

  task automatic t_jab();
    jab_dis_i = 1'b1;
    for (int i = 0; i < MP; i++) tick(1'b1, 1'b1);
    tick(1'b0, 1'b0);
    check("R9 valid despite jabber", tx_valid_o, 1);
    check("R9 enable blocked", tx_en_o, 0);
    tick(1'b1, 1'b1);
    check("R9 data blocked", tx_data_o, 0);
    jab_dis_i = 1'b0;
    tick(1'b1, 1'b1);
    check("R9 enable back", tx_en_o, 1);
    check("R7 data passes", tx_data_o, 1);
    tick(1'b1, 1'b0);
    check("R1 data low below threshold", tx_data_o, 0);
    check("R1 enable kept", tx_en_o, 1);
    jab_dis_i = 1'b1;
    tick(1'b1, 1'b1);
    check("R9 enable cut at once", tx_en_o, 0);
    check("R8 data low while cut", tx_data_o, 0);
    check("R9 valid kept", tx_valid_o, 1);
    jab_dis_i = 1'b0;
    quiet(TO + BL + 5);
  endtask

  initial begin
    #(200_000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_below_thr();
    t_short();
    t_single();
    t_blank();
    t_frame();
    t_jab();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule